// File: doc/BRIEF.md
# XOR Parametric Test Mode Controller

This block decides at reset release whether the chip enters a parametric XOR test mode, and once in that mode it drives the results of ten XOR chains onto output pins. Two strap pads do double duty. They are read as inputs while the external active-low reset is held. If both read low when reset is released, test mode is entered, and the same two pads are then turned around to drive two of the chain results.

Each chain folds a parameter-selected group of pin inputs into one bit by XOR reduction, registered once per clock. Pins on an exclusion mask belong to no chain. The chain results stay low until a settling window of clocks after test entry has passed, and a ready flag marks the end of that window. A wide-mode input copies every chain result onto a second output bus, so each result leaves on two pins. There is no data stream at the edge of the block. Every pin is a plain level control or status, with no valid/ready handshake and no back-pressure.

The power-good input resets the block asynchronously. A test run holds power-good, reset and both straps low while the clock runs. It then raises power-good and later releases reset. The straps are released after that, and the tester waits for ready before reading the chains.

Top module: `xor_test_ctrl`

## Requirements
- R1: While pwr_good is low, test_active, ready, both strap output enables, both strap outputs, chain_out and chain_mirror are all 0.
- R2: At the first rising clock edge where rst_n is seen high after being low (or after pwr_good rose), with pwr_good high, test_active becomes 1 after that edge if strap_a_in and strap_b_in are both 0 at that edge.
- R3: If either strap reads 1 at that release edge, test_active, ready, both output enables and all chain outputs stay 0 while rst_n stays high.
- R4: ready is 0 for the first 31 clock edges after the edge that sets test_active, and it becomes 1 after the 32nd (SETTLE_CLKS = 32).
- R5: rst_n low at a clock edge clears test_active, ready and both output enables after that edge.
- R6: Chain i (i = 0..9) is the XOR of pin_in[p] over every pin p with p mod 10 = i, leaving out pins set in the exclusion mask (default: pins 0 and 5). The result is registered one clock after pin_in is sampled. chain_out is 0 whenever ready is 0.
- R7: strap_a_oe and strap_b_oe equal test_active. strap_a_out carries chain_out[2] and strap_b_out carries chain_out[3].
- R8: chain_mirror equals chain_out while wide_mode is 1, and it is 0 while wide_mode is 0.
- R9: After test entry, the strap input values have no effect on test_active, ready or the chain outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Power good; low resets the block asynchronously |
| rst_n | input | 1 | External active-low reset; its release samples the straps |
| strap_a_in | input | 1 | Strap pad A, input side |
| strap_b_in | input | 1 | Strap pad B, input side |
| wide_mode | input | 1 | Copy the chain results onto chain_mirror |
| pin_in | input | 40 | Pin inputs that feed the chains |
| strap_a_oe | output | 1 | Output enable for strap pad A |
| strap_a_out | output | 1 | Strap pad A drive value (chain 2) |
| strap_b_oe | output | 1 | Output enable for strap pad B |
| strap_b_out | output | 1 | Strap pad B drive value (chain 3) |
| chain_out | output | 10 | XOR chain results |
| chain_mirror | output | 10 | Second copy of the chain results in wide mode |
| test_active | output | 1 | Test mode entered |
| ready | output | 1 | Settling window over; chains valid |

## Verification
The assertions check on every cycle the following rules:
- Test entry follows a low strap sample and high power-good.
- Reset clears the mode on the next edge.
- The settling counter advances by one per clock.
- ready never appears outside test mode.
- No chain result or pad drive shows before ready.

The bench scenarios cover the behaviours a property cannot capture alone:
- The exact 32-clock length of the window.
- The XOR values for random pin patterns against the exclusion mask.
- The strap refusal cases.
- Strap inputs that change after entry and are ignored.

// File: rtl/xtm_pkg.sv
package xtm_pkg;
  localparam int unsigned XTM_NPINS  = 40;
  localparam int unsigned XTM_NCHAIN = 10;
  localparam int unsigned XTM_SETTLE = 32;

  typedef enum logic [1:0] {
    XTM_FUNC    = 2'd0,
    XTM_SETTLING = 2'd1,
    XTM_VALID   = 2'd2
  } xtm_phase_e;
endpackage

// File: rtl/xtm_entry.sv
module xtm_entry (
  input  logic clk,
  input  logic pwr_good,
  input  logic rst_n,
  input  logic strap_a_in,
  input  logic strap_b_in,
  output logic test_mode
);
  logic rst_q;
  logic release_edge;

  assign release_edge = rst_n & ~rst_q;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      rst_q     <= 1'b0;
      test_mode <= 1'b0;
    end else begin
      rst_q <= rst_n;
      if (!rst_n)
        test_mode <= 1'b0;
      else if (release_edge)
        test_mode <= ~strap_a_in & ~strap_b_in;
    end
  end

  // R2: entry only follows low straps
  a_r2_entry_needs_low_straps: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(test_mode) |-> ($past(!strap_a_in) && $past(!strap_b_in) && $past(rst_n)));
  // R5: reset clears the mode
  a_r5_reset_leaves_mode: assert property (@(posedge clk) disable iff (!pwr_good)
    !rst_n |=> !test_mode);
endmodule

// File: rtl/xtm_settle.sv
module xtm_settle #(
  parameter int unsigned SETTLE_CLKS = 32
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic test_mode,
  output logic ready
);
  localparam int unsigned CW = $clog2(SETTLE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)
      cnt <= '0;
    else if (!test_mode)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + CW'(1);
  end

  assign ready = test_mode && (cnt == LAST);

  // R4: counter advances one per clock while settling
  a_r4_count_step: assert property (@(posedge clk) disable iff (!pwr_good)
    (test_mode && cnt != LAST) |=> (!test_mode || cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/xtm_chain_bank.sv
module xtm_chain_bank #(
  parameter int unsigned NPINS  = 40,
  parameter int unsigned NCHAIN = 10,
  parameter logic [NPINS-1:0] EXCL_MASK = '0
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NCHAIN-1:0] chain_q
);
  logic [NCHAIN-1:0] chain_d;

  for (genvar i = 0; i < NCHAIN; i++) begin : g_chain
    logic [NPINS-1:0] member;
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign member[p] = ((p % NCHAIN) == i) && !EXCL_MASK[p];
    end
    assign chain_d[i] = ^(pin_in & member);
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) chain_q <= '0;
    else           chain_q <= chain_d;
  end
endmodule

// File: rtl/xor_test_ctrl.sv
module xor_test_ctrl
  import xtm_pkg::*;
#(
  parameter int unsigned NPINS       = XTM_NPINS,
  parameter int unsigned NCHAIN      = XTM_NCHAIN,
  parameter int unsigned SETTLE_CLKS = XTM_SETTLE,
  parameter int unsigned STRAP_A_CH  = 2,
  parameter int unsigned STRAP_B_CH  = 3,
  parameter logic [NPINS-1:0] EXCL_MASK = NPINS'(40'h00_0000_0021)
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              rst_n,
  input  logic              strap_a_in,
  input  logic              strap_b_in,
  input  logic              wide_mode,
  input  logic [NPINS-1:0]  pin_in,
  output logic              strap_a_oe,
  output logic              strap_a_out,
  output logic              strap_b_oe,
  output logic              strap_b_out,
  output logic [NCHAIN-1:0] chain_out,
  output logic [NCHAIN-1:0] chain_mirror,
  output logic              test_active,
  output logic              ready
);
  logic              test_mode;
  logic              settled;
  logic [NCHAIN-1:0] chain_q;
  xtm_phase_e        phase;

  xtm_entry u_entry (
    .clk(clk), .pwr_good(pwr_good), .rst_n(rst_n),
    .strap_a_in(strap_a_in), .strap_b_in(strap_b_in), .test_mode(test_mode)
  );

  xtm_settle #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
    .clk(clk), .pwr_good(pwr_good), .test_mode(test_mode), .ready(settled)
  );

  xtm_chain_bank #(.NPINS(NPINS), .NCHAIN(NCHAIN), .EXCL_MASK(EXCL_MASK)) u_bank (
    .clk(clk), .pwr_good(pwr_good), .pin_in(pin_in), .chain_q(chain_q)
  );

  always_comb begin
    if (!test_mode)   phase = XTM_FUNC;
    else if (settled) phase = XTM_VALID;
    else              phase = XTM_SETTLING;
  end

  assign test_active  = test_mode;
  assign ready        = (phase == XTM_VALID);
  assign chain_out    = ready ? chain_q : '0;
  assign chain_mirror = wide_mode ? chain_out : '0;
  assign strap_a_oe   = test_mode;
  assign strap_b_oe   = test_mode;
  assign strap_a_out  = chain_out[STRAP_A_CH];
  assign strap_b_out  = chain_out[STRAP_B_CH];

  // R4: ready only inside test mode
  a_r4_ready_in_mode: assert property (@(posedge clk) disable iff (!pwr_good)
    settled |-> test_mode);
  // R6: chains held low before settling ends
  a_r6_low_until_ready: assert property (@(posedge clk) disable iff (!pwr_good)
    !settled |-> (chain_out == '0 && chain_mirror == '0));
  // R7: pads carry nothing before ready
  a_r7_pad_quiet: assert property (@(posedge clk) disable iff (!pwr_good)
    !settled |-> (!strap_a_out && !strap_b_out));
endmodule

// File: tb/xor_test_ctrl_tb_top.sv
module xor_test_ctrl_tb_top;
  localparam int NP = 40;
  localparam int NC = 10;

  logic clk = 0;
  logic pwr_good, rst_n, strap_a_in, strap_b_in, wide_mode;
  logic [NP-1:0] pin_in;
  logic strap_a_oe, strap_a_out, strap_b_oe, strap_b_out, test_active, ready;
  logic [NC-1:0] chain_out, chain_mirror;

  int checks = 0;
  int errors = 0;
  logic [NP-1:0] prev_pins;

  always #4 clk = ~clk;

  xor_test_ctrl dut_i (
    .clk(clk), .pwr_good(pwr_good), .rst_n(rst_n),
    .strap_a_in(strap_a_in), .strap_b_in(strap_b_in), .wide_mode(wide_mode),
    .pin_in(pin_in), .strap_a_oe(strap_a_oe), .strap_a_out(strap_a_out),
    .strap_b_oe(strap_b_oe), .strap_b_out(strap_b_out), .chain_out(chain_out),
    .chain_mirror(chain_mirror), .test_active(test_active), .ready(ready)
  );

  function automatic logic [NC-1:0] exp_chain(input logic [NP-1:0] p);
    logic [NC-1:0] r = '0;
    for (int k = 0; k < NP; k++)
      if (k != 0 && k != 5) r[k % NC] = r[k % NC] ^ p[k];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_entry(input logic sa, input logic sb);
    pwr_good = 0; rst_n = 0; strap_a_in = sa; strap_b_in = sb;
    repeat (20) step();
    pwr_good = 1;
    repeat (15) step();
    rst_n = 1;
    step();
    strap_a_in = 1; strap_b_in = 1;
  endtask

  task automatic check_window();
    int early = 0;
    for (int k = 1; k <= 31; k++) begin
      step();
      if (ready) early++;
    end
    check("R4 ready early", 32'(early), 0);
    step();
    check("R4 ready at 32", {31'b0, ready}, 1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    pwr_good = 0; rst_n = 0; strap_a_in = 0; strap_b_in = 0;
    wide_mode = 1; pin_in = '1;
    repeat (3) step();
    check("R1 reset flags", {28'b0, test_active, ready, strap_a_oe, strap_b_oe}, 0);
    check("R1 reset chains", {12'b0, chain_out, chain_mirror}, 0);

    // refused entry: strap A high, then strap B high
    run_entry(1, 0);
    repeat (40) step();
    check("R3 strapA refused", {29'b0, test_active, ready, strap_a_oe | strap_b_oe}, 0);
    check("R3 strapA chains", {22'b0, chain_out}, 0);
    run_entry(0, 1);
    repeat (40) step();
    check("R3 strapB refused", {29'b0, test_active, ready, strap_a_oe | strap_b_oe}, 0);

    // valid entry
    run_entry(0, 0);
    check("R2 entered", {31'b0, test_active}, 1);
    check("R7 oe on entry", {30'b0, strap_a_oe, strap_b_oe}, 2'b11);
    check("R6 low before ready", {22'b0, chain_out}, 0);
    check_window();

    // directed and random chain patterns
    for (int it = 0; it < 200; it++) begin
      logic [NP-1:0] pv;
      if (it == 0) pv = '1;
      else if (it == 1) pv = 40'h00_0000_0021;
      else if (it == 2) pv = '0;
      else pv = {$urandom, $urandom};
      pin_in = pv;
      wide_mode = $urandom_range(0, 1);
      strap_a_in = $urandom_range(0, 1);
      strap_b_in = $urandom_range(0, 1);
      step();
      check("R6 chain", {22'b0, chain_out}, {22'b0, exp_chain(pv)});
      check("R8 mirror", {22'b0, chain_mirror},
            {22'b0, (wide_mode ? exp_chain(pv) : 10'b0)});
      check("R7 pads", {30'b0, strap_a_out, strap_b_out},
            {30'b0, exp_chain(pv)[2], exp_chain(pv)[3]});
      check("R9 mode kept", {30'b0, test_active, ready}, 2'b11);
    end

    // reset reassertion leaves test mode
    rst_n = 0;
    step();
    check("R5 reset exit", {28'b0, test_active, ready, strap_a_oe, strap_b_oe}, 0);
    check("R5 reset chains", {22'b0, chain_out}, 0);

    // re-entry, then pwr_good loss
    strap_a_in = 0; strap_b_in = 0;
    step();
    rst_n = 1;
    step();
    check("R2 re-entry", {31'b0, test_active}, 1);
    check_window();
    #2 pwr_good = 0;
    #1;
    check("R1 pwr loss", {28'b0, test_active, ready, strap_a_oe, strap_b_oe}, 0);
    check("R1 pwr loss chains", {12'b0, chain_out, chain_mirror}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule